// File: doc/BRIEF.md
# Pin-Change and Timer Interrupt Controller

This block gathers the interrupt sources of a small 8-bit microcontroller into one request line for the CPU. Five general-purpose port pins are watched for any change of level. A sixth pin acts as a dedicated external interrupt and responds only to a rising edge. A timer overflow strobe is the third kind of source. Every pin input first passes through a two-stage synchroniser. A change or edge is found by comparing the synchronised level with the level seen on the previous clock.

Each source sets a sticky flag. Each flag has its own enable. The flags and enables are spread over three byte-wide registers, which are reached through a simple select/write/read port. Software clears a flag by writing 0 to its bit. Writing 1 to a flag bit leaves it as it is. The CPU request is registered, and it is high in the cycle after any flag and its enable are both set.

Top module: `pinchg_irq_ctrl`

## Requirements
- R1: After reset, all three registers read 0 and `irq_o` is 0.
- R2: A change of level in either direction on `pin_i[n]` (n = 1..5) sets bit n of register 0 (pin flags). The bit reads 1 after the third rising clock edge that follows the change, and it still reads 0 after the second.
- R3: A rising edge on `pin_i[0]` sets bit 1 of register 2 (external flag) with the same three-edge latency. A falling edge on `pin_i[0]` sets no flag.
- R4: A one-cycle high on `tmr_ovf_i` sets bit 2 of register 2 (timer flag) on the next rising edge.
- R5: Reserved bits read 0 at all times: bits 0, 6 and 7 of registers 0 and 1, bits 0, 3, 6 and 7 of register 2, and every bit of select value 3.
- R6: Flags are sticky. A write clears every flag bit whose data bit is 0 and leaves unchanged every flag bit whose data bit is 1. A write never sets a flag.
- R7: If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends set.
- R8: `irq_o` is 1 in the cycle after some flag and its matching enable are both 1, and 0 in the cycle after no such pair exists.
- R9: Enables are plain read/write bits: pin enables at bits 1..5 of register 1, the external enable at bit 4 and the timer enable at bit 5 of register 2. A value of 1 enables the source.
- R10: A flag whose enable is 0 still sets and reads back, but it does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 6 | Asynchronous pins; bit 0 is the external interrupt, bits 1..5 are watched for change |
| tmr_ovf_i | input | 1 | Timer overflow strobe, synchronous, one cycle per event |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_sel_i | input | 2 | Register select: 0 pin flags, 1 pin enables, 2 external/timer flags and enables, 3 unused |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Registered interrupt request to the CPU |

## Verification
The change detector is driven with rising and falling steps on each watched pin in turn. This shows that every pin maps to its own flag bit and that both directions count. The external pin gets both edges, which separates edge-only detection from any-change detection. The timing of the flag is sampled one edge early and then on time, to pin down the synchroniser depth. The timer strobe is applied on its own, together with a clearing write, and with its enable set or cleared. This separates set-over-clear priority, the gating by the enable, and the one-cycle delay of the request register.

// File: rtl/pcic_pkg.sv
// Package: shared register selects and field positions of the interrupt controller.
// Assumes: registers are 8 bits wide and are addressed by a 2-bit select.
package pcic_pkg;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        SEL_PIN_FLAG = 2'd0,
        SEL_PIN_EN   = 2'd1,
        SEL_MISC     = 2'd2,
        SEL_NONE     = 2'd3
    } reg_sel_e;

    // Bit positions inside the misc register (neighbour software decodes these)
    localparam int MISC_EXT_FLAG = 1;
    localparam int MISC_TMR_FLAG = 2;
    localparam int MISC_EXT_EN   = 4;
    localparam int MISC_TMR_EN   = 5;
endpackage

// File: rtl/pcic_pin_sync.sv
// Module: pcic_pin_sync
// Brings asynchronous pins into the clock domain through STAGES flops, then
// reports an event per bit: any level change (RISE_ONLY=0) or rising edge only.
// Assumes: pins are low during reset, so no event is reported on reset release.
module pcic_pin_sync #(
    parameter int W         = 5,
    parameter int STAGES    = 2,
    parameter bit RISE_ONLY = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] event_o
);
    logic [STAGES-1:0][W-1:0] sync_q;
    logic [W-1:0]             prev_q;
    logic [W-1:0]             level;

    assign level = sync_q[STAGES-1];

    // First synchroniser stage samples the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= '0;
        else        sync_q[0] <= pin_i;
    end

    // Remaining synchroniser stages
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[k] <= '0;
            else        sync_q[k] <= sync_q[k-1];
        end
    end

    // Hold last cycle's synchronised level for comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    // Event kind chosen by parameter
    if (RISE_ONLY) begin : g_rise
        assign event_o = level & ~prev_q;
    end else begin : g_any
        assign event_o = level ^ prev_q;
    end
endmodule

// File: rtl/pcic_flag_bank.sv
// Module: pcic_flag_bank
// A row of sticky flags: hardware sets, software clears by writing 0.
// Assumes: a set and a clear in the same cycle resolve to set.
module pcic_flag_bank #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] flag_o
);
    logic [W-1:0] flag_q;
    logic [W-1:0] kept;

    assign kept   = wr_i ? (flag_q & wdata_i) : flag_q;
    assign flag_o = flag_q;

    // Update flags: clear by write-zero, then OR in new events
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= kept | set_i;
    end
endmodule

// File: rtl/pinchg_irq_ctrl.sv
// Module: pinchg_irq_ctrl (top)
// Collects five pin-change sources, one rising-edge external pin and a timer
// overflow into sticky flags with enables, exposes them as three registers and
// drives one registered interrupt request.
// Assumes: tmr_ovf_i is synchronous to clk; pins are asynchronous.
module pinchg_irq_ctrl
    import pcic_pkg::*;
#(
    parameter int N_CHG_PINS  = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_CHG_PINS:0]   pin_i,
    input  logic                  tmr_ovf_i,
    input  logic                  reg_wr_i,
    input  logic [1:0]            reg_sel_i,
    input  logic [REG_W-1:0]      reg_wdata_i,
    output logic [REG_W-1:0]      reg_rdata_o,
    output logic                  irq_o
);
    localparam int N = N_CHG_PINS;

    reg_sel_e       sel;
    logic [N-1:0]   chg_evt;
    logic [0:0]     ext_evt;
    logic [N-1:0]   pin_flag_q;
    logic [N-1:0]   pin_en_q;
    logic [1:0]     misc_flag_q;
    logic           ext_en_q;
    logic           tmr_en_q;
    logic           wr_pin_flag;
    logic           wr_misc;
    logic           irq_q;
    logic           irq_d;
    logic           unused_wdata_par;

    assign sel              = reg_sel_e'(reg_sel_i);
    assign wr_pin_flag      = reg_wr_i && (sel == SEL_PIN_FLAG);
    assign wr_misc          = reg_wr_i && (sel == SEL_MISC);
    assign unused_wdata_par = ^reg_wdata_i;

    pcic_pin_sync #(.W(N), .STAGES(SYNC_STAGES), .RISE_ONLY(1'b0)) u_chg_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i[N:1]), .event_o(chg_evt)
    );

    pcic_pin_sync #(.W(1), .STAGES(SYNC_STAGES), .RISE_ONLY(1'b1)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i[0:0]), .event_o(ext_evt)
    );

    pcic_flag_bank #(.W(N)) u_pin_flags (
        .clk(clk), .rst_n(rst_n), .set_i(chg_evt), .wr_i(wr_pin_flag),
        .wdata_i(reg_wdata_i[N:1]), .flag_o(pin_flag_q)
    );

    // misc flag bank: index 0 = external, index 1 = timer
    pcic_flag_bank #(.W(2)) u_misc_flags (
        .clk(clk), .rst_n(rst_n), .set_i({tmr_ovf_i, ext_evt[0]}), .wr_i(wr_misc),
        .wdata_i({reg_wdata_i[MISC_TMR_FLAG], reg_wdata_i[MISC_EXT_FLAG]}),
        .flag_o(misc_flag_q)
    );

    // Enable registers are written directly from the data bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_en_q <= '0;
            ext_en_q <= 1'b0;
            tmr_en_q <= 1'b0;
        end else if (reg_wr_i) begin
            if (sel == SEL_PIN_EN) pin_en_q <= reg_wdata_i[N:1];
            if (sel == SEL_MISC) begin
                ext_en_q <= reg_wdata_i[MISC_EXT_EN];
                tmr_en_q <= reg_wdata_i[MISC_TMR_EN];
            end
        end
    end

    // Read mux, reserved bits stay zero
    always_comb begin
        reg_rdata_o = '0;
        unique case (sel)
            SEL_PIN_FLAG: reg_rdata_o[N:1] = pin_flag_q;
            SEL_PIN_EN:   reg_rdata_o[N:1] = pin_en_q;
            SEL_MISC: begin
                reg_rdata_o[MISC_EXT_FLAG] = misc_flag_q[0];
                reg_rdata_o[MISC_TMR_FLAG] = misc_flag_q[1];
                reg_rdata_o[MISC_EXT_EN]   = ext_en_q;
                reg_rdata_o[MISC_TMR_EN]   = tmr_en_q;
            end
            default:      reg_rdata_o = '0;
        endcase
    end

    // Combine flag AND enable across all sources
    assign irq_d = (|(pin_flag_q & pin_en_q))
                 | (misc_flag_q[0] & ext_en_q)
                 | (misc_flag_q[1] & tmr_en_q);

    // Register the request for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/pcic_checker.sv
// Module: pcic_checker
// Temporal properties of the interrupt controller, bound into the top.
// Assumes: sampled on the rising edge, disabled while reset is low.
module pcic_checker #(
    parameter int N = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tmr_ovf_i,
    input logic         reg_wr_i,
    input logic [1:0]   reg_sel_i,
    input logic [7:0]   reg_rdata_o,
    input logic         irq_o,
    input logic [N-1:0] pin_flag,
    input logic [N-1:0] pin_en,
    input logic [1:0]   misc_flag,
    input logic         ext_en,
    input logic         tmr_en
);
    logic any_pair;
    assign any_pair = (|(pin_flag & pin_en)) | (misc_flag[0] & ext_en) | (misc_flag[1] & tmr_en);

    AST_TMR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf_i |=> misc_flag[1]); // R4

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ovf_i && reg_wr_i && reg_sel_i == 2'd2) |=> misc_flag[1]); // R7

    AST_PIN_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_sel_i == 2'd0) |=> ((pin_flag & $past(pin_flag)) == $past(pin_flag))); // R6

    AST_RSV_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_i != 2'd2) |-> (reg_rdata_o[0] == 1'b0 && reg_rdata_o[7:6] == 2'b00)); // R5

    AST_IRQ_FOLLOWS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        any_pair |=> irq_o); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pair |=> !irq_o); // R8
endmodule

bind pinchg_irq_ctrl pcic_checker #(.N(N_CHG_PINS)) u_pcic_checker (
    .clk(clk), .rst_n(rst_n), .tmr_ovf_i(tmr_ovf_i), .reg_wr_i(reg_wr_i),
    .reg_sel_i(reg_sel_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
    .pin_flag(pin_flag_q), .pin_en(pin_en_q), .misc_flag(misc_flag_q),
    .ext_en(ext_en_q), .tmr_en(tmr_en_q)
);

// File: tb/pinchg_irq_ctrl_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module pinchg_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pin_i = '0;
    logic       tmr_ovf_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [1:0] reg_sel_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinchg_irq_ctrl u_pinchg_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .tmr_ovf_i(tmr_ovf_i),
        .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Call just after a negedge; write lands on the next posedge
    task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
        reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [7:0] v);
        reg_sel_i = sel;
        #1;
        v = reg_rdata_o;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int s = 0; s < 4; s++) begin
            rd_reg(s[1:0], v);
            check("R1 reset register", v, 8'h00);
        end
        check("R1 reset irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        wr_reg(2'd1, 8'hFF);
        rd_reg(2'd1, v); check("R9 R5 pin enables", v, 8'h3E);
        wr_reg(2'd2, 8'hFF);
        rd_reg(2'd2, v); check("R9 R5 R6 misc enables, no flag set", v, 8'h30);
        wr_reg(2'd0, 8'hFF);
        rd_reg(2'd0, v); check("R6 writing 1 sets no pin flag", v, 8'h00);
        wr_reg(2'd3, 8'hFF);
        rd_reg(2'd3, v); check("R5 select 3 reads zero", v, 8'h00);
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd2, 8'h00);
        rd_reg(2'd2, v); check("R9 misc enables cleared", v, 8'h00);
    endtask

    task automatic t_pin_change();
        logic [7:0] v;
        for (int n = 1; n <= 5; n++) begin
            for (int dir = 0; dir < 2; dir++) begin
                pin_i[n] = (dir == 0);
                @(negedge clk); @(negedge clk);
                rd_reg(2'd0, v); check("R2 flag not yet set after two edges", v, 8'h00);
                @(negedge clk);
                rd_reg(2'd0, v); check("R2 change flag set", v, 8'h01 << n);
                check("R10 disabled flag gives no irq", {7'd0, irq_o}, 8'h00);
                wr_reg(2'd0, ~(8'h01 << n));
                rd_reg(2'd0, v); check("R6 write 0 clears flag", v, 8'h00);
            end
        end
    endtask

    task automatic t_ext_pin();
        logic [7:0] v;
        pin_i[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd_reg(2'd2, v); check("R3 ext flag not yet set", v, 8'h00);
        @(negedge clk);
        rd_reg(2'd2, v); check("R3 ext rising edge sets bit 1", v, 8'h02);
        rd_reg(2'd0, v); check("R3 ext pin does not touch pin flags", v, 8'h00);
        wr_reg(2'd2, 8'h00);
        pin_i[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd_reg(2'd2, v); check("R3 falling edge sets nothing", v, 8'h00);
    endtask

    task automatic t_timer();
        logic [7:0] v;
        tmr_ovf_i = 1'b1;
        @(negedge clk);
        tmr_ovf_i = 1'b0;
        rd_reg(2'd2, v); check("R4 timer flag set next edge", v, 8'h04);
        wr_reg(2'd2, 8'h02);
        rd_reg(2'd2, v); check("R6 write clears timer flag only", v, 8'h00);
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        tmr_ovf_i = 1'b1;
        @(negedge clk);
        rd_reg(2'd2, v); check("R4 timer flag set", v, 8'h04);
        tmr_ovf_i = 1'b1;
        wr_reg(2'd2, 8'h00);
        tmr_ovf_i = 1'b0;
        rd_reg(2'd2, v); check("R7 set beats same-cycle clear", v, 8'h04);
        wr_reg(2'd2, 8'h00);
        rd_reg(2'd2, v); check("R7 later clear works", v, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr_reg(2'd2, 8'h20);
        tmr_ovf_i = 1'b1;
        @(negedge clk);
        tmr_ovf_i = 1'b0;
        check("R8 irq not before register delay", {7'd0, irq_o}, 8'h00);
        @(negedge clk);
        check("R8 irq on enabled timer flag", {7'd0, irq_o}, 8'h01);
        wr_reg(2'd2, 8'h20);
        check("R8 irq held one cycle after clear", {7'd0, irq_o}, 8'h01);
        @(negedge clk);
        check("R8 irq drops after clear", {7'd0, irq_o}, 8'h00);
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd1, 8'h08);
        pin_i[3] = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 irq not yet for pin 3", {7'd0, irq_o}, 8'h00);
        @(negedge clk);
        check("R8 irq for enabled pin 3", {7'd0, irq_o}, 8'h01);
        wr_reg(2'd1, 8'h00);
        @(negedge clk);
        check("R10 irq drops when enable cleared", {7'd0, irq_o}, 8'h00);
        rd_reg(2'd0, v); check("R10 flag kept with enable off", v, 8'h08);
        wr_reg(2'd0, 8'h00);
        pin_i[3] = 1'b0;
        repeat (4) @(negedge clk);
        wr_reg(2'd0, 8'h00);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reserved();
        t_pin_change();
        t_ext_pin();
        t_timer();
        t_set_wins();
        t_irq();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule